// File: doc/BRIEF.md
# I2C Controller Address Phase Framer

This block sits between a transaction requester and a byte-level I2C shifter in a controller. On a start strobe it captures a target address held in plain 7-bit or 10-bit form, a width-select flag and a read/write flag. It then hands the shifter the address byte or bytes with the direction bit already placed. After that it forwards a given number of payload bytes, such as register offsets or write data. Each byte goes out with a valid flag. The shifter answers once per byte with a result pulse that carries the acknowledge bit sampled on the ninth clock and an arbitration-lost flag.

The framer records where a transaction ended. A NACK on the first address byte, a NACK on the second address byte of a 10-bit address, a NACK on a payload byte and a lost arbitration each give their own result code. A clean finish gives a code of its own too. On any failure the block issues no further bytes. Software can then tell an address or capability fault from a payload-level refusal without a logic analyser.

Top module: `i2c_addr_framer`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, byte-valid and payload-take are all low, the byte kind is 0 and the result code is 0.
- R2: In 7-bit mode the single address byte is the address bits 6..0 in byte bits 7..1, with the read flag (1 = read) in bit 0; address 0x50 gives 0xA0 for a write and 0xA1 for a read.
- R3: In 10-bit mode the first byte is binary 11110, then address bits 9..8, then the read flag in bit 0; the second byte is address bits 7..0. The byte kind output reads 1 for the first address byte, 2 for the second, 3 for payload and 0 when idle.
- R4: A NACK on the first address byte (in either mode) ends the transaction with result code 1; no byte is offered afterwards.
- R5: A NACK on the second address byte of a 10-bit address ends the transaction with result code 2.
- R6: A NACK on any payload byte ends the transaction with result code 3.
- R7: Arbitration lost on any byte ends the transaction with result code 4, taking precedence over a NACK reported at the same time.
- R8: Payload bytes are offered only after every address byte is acknowledged; exactly the requested count of them is offered, each taken from the payload input, and the payload-take output pulses for one cycle after each acknowledged payload byte.
- R9: When all address and payload bytes are acknowledged, the result code is 0.
- R10: A start strobe while busy is ignored, and the address, mode and direction captured at the accepted start stay in use until the end.
- R11: A shifter result pulse while idle has no effect on any output.
- R12: Completion shows as a single-cycle done pulse in the cycle after the final result. Busy and byte-valid are already low in that cycle, and the result code holds until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| mode10_i | input | 1 | 1 selects a 10-bit address |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 10 | Target address, right-aligned |
| pay_len_i | input | CNT_W | Number of payload bytes after the address |
| pay_data_i | input | 8 | Current payload byte |
| pay_take_o | output | 1 | Pulse: current payload byte was acknowledged |
| tx_valid_o | output | 1 | A byte is offered to the shifter |
| tx_kind_o | output | 2 | 0 none, 1 first address, 2 second address, 3 payload |
| tx_byte_o | output | 8 | Byte to shift out |
| ack_valid_i | input | 1 | Shifter result pulse for the offered byte |
| ack_nack_i | input | 1 | 1 = NACK sampled on the ninth clock |
| arb_lost_i | input | 1 | 1 = arbitration lost during this byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Result code of the last transaction |

## Verification
A corrupted phase register shows in the next cycle as a wrong byte kind, a stray byte-valid or an address byte of the other format. A wrong payload counter shows as one payload byte too many or too few before done, or as a missing take pulse. A badly captured request shows as a shifted or mis-prefixed address byte in the first cycle after the strobe. A stray start accepted mid-transaction shows as a changed byte on the following cycle. The reference model compares every output on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/i2c_afr_pkg.sv
package i2c_afr_pkg;

   localparam int ADDR_W = 10;
   localparam int BYTE_W = 8;

   localparam logic [4:0] TEN_PREFIX = 5'b11110;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADR1 = 2'd1,
      PH_ADR2 = 2'd2,
      PH_DATA = 2'd3
   } phase_t;

   typedef enum logic [2:0] {
      RC_OK       = 3'd0,
      RC_NACK_A1  = 3'd1,
      RC_NACK_A2  = 3'd2,
      RC_NACK_DAT = 3'd3,
      RC_ARB_LOST = 3'd4
   } result_t;

   typedef struct packed {
      logic              ten;
      logic              rnw;
      logic [ADDR_W-1:0] addr;
   } req_t;

endpackage

// File: rtl/i2c_afr_req_latch.sv
module i2c_afr_req_latch
   import i2c_afr_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              mode10_i,
   input  logic              rnw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output req_t              req_o
);

   logic ten_eff;

   generate
      if (TEN_BIT_EN) begin : g_ten
         assign ten_eff = mode10_i;
      end else begin : g_seven
         assign ten_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o <= '0;
      end else if (accept_i) begin
         req_o.ten  <= ten_eff;
         req_o.rnw  <= rnw_i;
         req_o.addr <= addr_i;
      end
   end

endmodule

// File: rtl/i2c_afr_seq.sv
module i2c_afr_seq
   import i2c_afr_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ten_i,
   input  logic [CNT_W-1:0] pay_len_i,
   input  logic             ack_valid_i,
   input  logic             ack_nack_i,
   input  logic             arb_lost_i,
   output logic             accept_o,
   output phase_t           phase_o,
   output logic             done_o,
   output logic             take_o,
   output result_t          result_o
);

   phase_t           phase_q, phase_n;
   logic [CNT_W-1:0] left_q, left_n;
   logic             fin_n, take_n;
   result_t          code_n;

   assign accept_o = start_i && (phase_q == PH_IDLE);
   assign phase_o  = phase_q;

   always_comb begin
      phase_n = phase_q;
      left_n  = left_q;
      fin_n   = 1'b0;
      take_n  = 1'b0;
      code_n  = RC_OK;
      case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               phase_n = PH_ADR1;
               left_n  = pay_len_i;
            end
         end
         PH_ADR1: begin
            if (ack_valid_i) begin
               if (arb_lost_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_ARB_LOST;
               end else if (ack_nack_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_NACK_A1;
               end else if (ten_i) begin
                  phase_n = PH_ADR2;
               end else if (left_q == '0) begin
                  fin_n = 1'b1;
               end else begin
                  phase_n = PH_DATA;
               end
            end
         end
         PH_ADR2: begin
            if (ack_valid_i) begin
               if (arb_lost_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_ARB_LOST;
               end else if (ack_nack_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_NACK_A2;
               end else if (left_q == '0) begin
                  fin_n = 1'b1;
               end else begin
                  phase_n = PH_DATA;
               end
            end
         end
         PH_DATA: begin
            if (ack_valid_i) begin
               if (arb_lost_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_ARB_LOST;
               end else if (ack_nack_i) begin
                  fin_n  = 1'b1;
                  code_n = RC_NACK_DAT;
               end else begin
                  take_n = 1'b1;
                  left_n = left_q - 1'b1;
                  if (left_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                     fin_n = 1'b1;
                  end
               end
            end
         end
         default: phase_n = PH_IDLE;
      endcase
      if (fin_n) begin
         phase_n = PH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         left_q   <= '0;
         done_o   <= 1'b0;
         take_o   <= 1'b0;
         result_o <= RC_OK;
      end else begin
         phase_q <= phase_n;
         left_q  <= left_n;
         done_o  <= fin_n;
         take_o  <= take_n;
         if (fin_n) begin
            result_o <= code_n;
         end
      end
   end

endmodule

// File: rtl/i2c_afr_byte_build.sv
module i2c_afr_byte_build
   import i2c_afr_pkg::*;
(
   input  phase_t            phase_i,
   input  req_t              req_i,
   input  logic [BYTE_W-1:0] pay_data_i,
   output logic [BYTE_W-1:0] byte_o
);

   logic [BYTE_W-1:0] seven_byte, ten_first, ten_second;

   assign seven_byte = {req_i.addr[6:0], req_i.rnw};
   assign ten_first  = {TEN_PREFIX, req_i.addr[9:8], req_i.rnw};
   assign ten_second = req_i.addr[7:0];

   always_comb begin
      case (phase_i)
         PH_ADR1: byte_o = req_i.ten ? ten_first : seven_byte;
         PH_ADR2: byte_o = ten_second;
         PH_DATA: byte_o = pay_data_i;
         default: byte_o = '0;
      endcase
   end

endmodule

// File: rtl/i2c_addr_framer.sv
module i2c_addr_framer
   import i2c_afr_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode10_i,
   input  logic             rnw_i,
   input  logic [9:0]       addr_i,
   input  logic [CNT_W-1:0] pay_len_i,
   input  logic [7:0]       pay_data_i,
   output logic             pay_take_o,
   output logic             tx_valid_o,
   output logic [1:0]       tx_kind_o,
   output logic [7:0]       tx_byte_o,
   input  logic             ack_valid_i,
   input  logic             ack_nack_i,
   input  logic             arb_lost_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       status_o
);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("i2c_addr_framer: CNT_W must lie in 1..16");
      end
   endgenerate

   logic    accept;
   req_t    req;
   phase_t  phase;
   result_t result;

   i2c_afr_req_latch #(.TEN_BIT_EN(TEN_BIT_EN)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .mode10_i (mode10_i),
      .rnw_i    (rnw_i),
      .addr_i   (addr_i),
      .req_o    (req)
   );

   i2c_afr_seq #(.CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .ten_i       (req.ten),
      .pay_len_i   (pay_len_i),
      .ack_valid_i (ack_valid_i),
      .ack_nack_i  (ack_nack_i),
      .arb_lost_i  (arb_lost_i),
      .accept_o    (accept),
      .phase_o     (phase),
      .done_o      (done_o),
      .take_o      (pay_take_o),
      .result_o    (result)
   );

   i2c_afr_byte_build u_build (
      .phase_i    (phase),
      .req_i      (req),
      .pay_data_i (pay_data_i),
      .byte_o     (tx_byte_o)
   );

   assign busy_o     = (phase != PH_IDLE);
   assign tx_valid_o = busy_o;
   assign tx_kind_o  = phase;
   assign status_o   = result;

endmodule

// File: rtl/i2c_afr_checker.sv
module i2c_afr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       ack_valid_i,
   input logic       ack_nack_i,
   input logic       arb_lost_i,
   input logic       pay_take_o,
   input logic       tx_valid_o,
   input logic [1:0] tx_kind_o,
   input logic [7:0] tx_byte_o,
   input logic       busy_o,
   input logic       done_o,
   input logic [2:0] status_o
);

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !tx_valid_o));

   a_r10_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   a_r10_addr_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$past(ack_valid_i) && tx_kind_o != 2'd3)
      |-> $stable(tx_byte_o));

   a_r4_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ack_valid_i && ack_nack_i) |=> (!tx_valid_o && done_o));

   a_r7_arb_code: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ack_valid_i && arb_lost_i) |=> (done_o && status_o == 3'd4));

   a_r8_take_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      pay_take_o |-> ($past(tx_kind_o) == 2'd3 && $past(ack_valid_i)));

   a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> (!busy_o && $stable(status_o)));

endmodule

bind i2c_addr_framer i2c_afr_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .ack_valid_i (ack_valid_i),
   .ack_nack_i  (ack_nack_i),
   .arb_lost_i  (arb_lost_i),
   .pay_take_o  (pay_take_o),
   .tx_valid_o  (tx_valid_o),
   .tx_kind_o   (tx_kind_o),
   .tx_byte_o   (tx_byte_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .status_o    (status_o)
);

// File: tb/i2c_addr_framer_test.sv
`timescale 1ns/1ps
module i2c_addr_framer_test;

   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, mode10_i = 1'b0, rnw_i = 1'b0;
   logic [9:0]    addr_i = '0;
   logic [CW-1:0] pay_len_i = '0;
   logic [7:0]    pay_data_i = 8'h30;
   logic          ack_valid_i = 1'b0, ack_nack_i = 1'b0, arb_lost_i = 1'b0;
   logic          pay_take_o, tx_valid_o, busy_o, done_o;
   logic [1:0]    tx_kind_o;
   logic [7:0]    tx_byte_o;
   logic [2:0]    status_o;

   int n_chk = 0, n_bad = 0, pay_idx = 0, cyc = 0;

   always #5 clk = ~clk;

   i2c_addr_framer #(.CNT_W(CW), .TEN_BIT_EN(1'b1)) uut (.*);

   // behavioural reference model
   int   m_ph = 0, m_left = 0, m_stat = 0;
   bit   m_ten, m_rnw, m_done, m_take;
   bit [9:0] m_addr;

   task automatic m_finish(input int code);
      m_ph = 0; m_stat = code; m_done = 1;
   endtask

   always @(posedge clk) begin
      m_done = 0; m_take = 0;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_stat = 0; m_ten = 0; m_rnw = 0; m_addr = 0;
      end else if (m_ph == 0) begin
         if (start_i) begin
            m_ph = 1; m_ten = mode10_i; m_rnw = rnw_i; m_addr = addr_i;
            m_left = int'(pay_len_i);
         end
      end else if (ack_valid_i) begin
         if (arb_lost_i) m_finish(4);
         else if (ack_nack_i) m_finish(m_ph == 1 ? 1 : (m_ph == 2 ? 2 : 3));
         else if (m_ph == 1 && m_ten) m_ph = 2;
         else if (m_ph == 3) begin
            m_take = 1; m_left--;
            if (m_left == 0) m_finish(0);
         end else if (m_left == 0) m_finish(0);
         else m_ph = 3;
      end
   end

   function automatic logic [7:0] exp_byte();
      case (m_ph)
         1: return m_ten ? {5'b11110, m_addr[9:8], m_rnw} : {m_addr[6:0], m_rnw};
         2: return m_addr[7:0];
         3: return pay_data_i;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   function automatic string stat_tag(input int s);
      case (s)
         0: return "R9";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   always @(negedge clk) begin
      cyc++;
      chk("R10", "busy", busy_o, m_ph != 0);
      chk("R4", "tx_valid", tx_valid_o, m_ph != 0);
      chk("R3", "tx_kind", tx_kind_o, m_ph);
      chk(m_ph == 3 ? "R8" : (m_ten ? "R3" : "R2"), "tx_byte", tx_byte_o, exp_byte());
      chk("R12", "done", done_o, m_done);
      chk("R8", "pay_take", pay_take_o, m_take);
      chk(stat_tag(m_stat), "status", status_o, m_stat);
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #2;
      if (pay_take_o) pay_idx++;
      pay_data_i = 8'h30 + 8'(pay_idx);
   endtask

   // run one transaction; byte indices count address bytes first
   task automatic txn(input bit ten, input bit rnw, input bit [9:0] a, input int len,
                      input int nack_at, input int arb_at, input bit poke,
                      input int exp_code, input string tag);
      int idx = 0;
      start_i = 1; mode10_i = ten; rnw_i = rnw; addr_i = a; pay_len_i = CW'(len);
      step();
      start_i = 0;
      for (int k = 0; k < 40 && !done_o; k++) begin
         if (poke) begin
            start_i = 1; mode10_i = !ten; rnw_i = !rnw; addr_i = ~a;   // R10 stray start
         end
         step();
         start_i = 0;
         ack_valid_i = 1; ack_nack_i = (idx == nack_at); arb_lost_i = (idx == arb_at);
         step();
         ack_valid_i = 0; ack_nack_i = 0; arb_lost_i = 0;
         idx++;
      end
      chk(tag, "final done", done_o, 1);
      chk(tag, "final code", status_o, exp_code);
      step();
   endtask

   initial begin
      repeat (3) step();
      chk("R1", "reset busy", busy_o, 0);
      chk("R1", "reset status", status_o, 0);
      rst_n = 1;
      step();
      chk("R1", "post-reset valid", tx_valid_o, 0);
      chk("R1", "post-reset done", done_o, 0);

      // R2 directed: 0x50 write gives 0xA0, read gives 0xA1
      start_i = 1; mode10_i = 0; rnw_i = 0; addr_i = 10'h050; pay_len_i = 0;
      step(); start_i = 0;
      chk("R2", "0x50 write byte", tx_byte_o, 8'hA0);
      ack_valid_i = 1; step(); ack_valid_i = 0; step();
      start_i = 1; rnw_i = 1;
      step(); start_i = 0;
      chk("R2", "0x50 read byte", tx_byte_o, 8'hA1);
      ack_valid_i = 1; step(); ack_valid_i = 0; step();

      txn(0, 0, 10'h050, 2, -1, -1, 0, 0, "R9");
      txn(1, 0, 10'h2A5, 1, -1, -1, 0, 0, "R3");
      txn(1, 1, 10'h3C7, 0, -1, -1, 1, 0, "R10");
      txn(0, 1, 10'h01F, 3, -1, -1, 1, 0, "R8");
      txn(0, 0, 10'h022, 2, 0, -1, 0, 1, "R4");
      txn(1, 0, 10'h155, 2, 0, -1, 0, 1, "R4");
      txn(1, 1, 10'h155, 2, 1, -1, 0, 2, "R5");
      txn(0, 0, 10'h044, 3, 2, -1, 0, 3, "R6");
      txn(1, 0, 10'h0F0, 3, 3, -1, 0, 3, "R6");
      txn(0, 0, 10'h066, 1, -1, 0, 0, 4, "R7");
      txn(1, 0, 10'h311, 2, 2, 2, 0, 4, "R7");
      txn(0, 0, 10'h07F, 15, -1, -1, 0, 0, "R8");

      // R11: result pulses while idle change nothing
      ack_valid_i = 1; ack_nack_i = 1; arb_lost_i = 1;
      step(); step();
      ack_valid_i = 0; ack_nack_i = 0; arb_lost_i = 0;
      chk("R11", "idle busy", busy_o, 0);
      chk("R11", "idle status kept", status_o, 0);
      chk("R11", "idle done", done_o, 0);
      step();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule